// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This controller steps a successive approximation conversion whose reference level comes from a row of equal unit capacitor lines. The lines are precharged according to the current trial code and then shorted together. A request first spends one cycle in a compute phase, in which the computing half of the array forms its sum. After that, each result bit takes two clock periods. The first is a precharge period, in which a thermometer-coded enable bus charges exactly as many unit lines as the trial value. The second is an averaging period, during which the shared sum line settles and the external comparator is read. The trial register is updated on the clock edge that closes the averaging period.

Resolution can be cut at run time. A conversion may stop after fewer than the full number of bits, and the bits it did not resolve come out as zero. A conversion at AP bits therefore occupies 1 + 2·AP strobed cycles, which is the per-bitplane cost of the surrounding array. After every finished conversion the sequencer swaps which array half converts and which half computes. The default build resolves 5 bits over 31 unit lines.

Top module: `sar_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `start`, all strobes, `done`, `line_en`, `code` and `cvt_half` are 0.
- R2: A `start` seen while idle is followed by exactly one cycle with `cmpt_stb` high. After that, for each bit from the MSB down, there is one cycle with `pch_stb` high and then one cycle with `avg_stb` high. At most one strobe is high in any cycle, and the conversion occupies 1 + 2·AP strobed cycles.
- R3: `prec` values 1..NBITS select AP = `prec`; a value of 0 or a value above NBITS selects AP = NBITS. The value is captured when the conversion is accepted.
- R4: In a `pch_stb` cycle, `line_en` has exactly as many bits set as the trial value, and they are lines 0 up to trial−1. Outside `pch_stb` cycles, `line_en` is all zero.
- R5: The trial value begins at midscale, 2^(NBITS−1). `cmp_hi` is sampled at the clock edge that ends each `avg_stb` cycle. A value of 1 keeps the trial bit and 0 clears it. On that same edge the next lower bit is set, unless the bit just resolved was the last one.
- R6: With `cmp_hi` = (input ≥ reference lines), the final `code` equals the input value with its lowest NBITS−AP bits forced to zero. `code` holds that value until the next conversion completes.
- R7: `cvt_half` resets to 0 and inverts in the same cycle that `done` rises, once per completed conversion.
- R8: `start` is ignored while a conversion is in progress. A pulse there changes neither the strobe sequence nor the result.
- R9: `done` is high for exactly one cycle, namely the cycle after the last `avg_stb` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| prec | input | PW | Requested result precision in bits |
| cmp_hi | input | 1 | Comparator: compute-side sum at or above reference |
| line_en | output | NLINES | Thermometer precharge enables for unit lines |
| cmpt_stb | output | 1 | Compute phase strobe |
| pch_stb | output | 1 | Reference precharge strobe |
| avg_stb | output | 1 | Average/compare strobe |
| cvt_half | output | 1 | Which half converts (0 = half A) |
| code | output | NBITS | Conversion result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench covers every input level at every legal precision, and also the out-of-range precision codes 0 and 7. It models an ideal comparator from the enables issued in the previous precharge cycle. The corner cases are the following:
- At the extremes 0 and 31, an off-by-one in the thermometer fill, or in how the next bit is set, would show up as a wrong line count or a saturated code.
- At truncated precisions, a design that kept iterating or left a low bit set would return stray low bits, and `done` would arrive late.
- A `start` pulse in the middle of a conversion would restart or lengthen a design that did not block it.
- Role swapping that was tied to `start` instead of to completion would leave `cvt_half` stuck or flipping twice.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMPT = 2'd1,
      ST_PCH  = 2'd2,
      ST_AVG  = 2'd3
   } sar_state_t;
endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
   import sar_pkg::*;
#(
   parameter int unsigned NBITS = 5,
   parameter int unsigned PW    = $clog2(NBITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] prec,
   output logic          cmpt_stb,
   output logic          pch_stb,
   output logic          avg_stb,
   output logic [PW-1:0] bit_idx,
   output logic          last_bit,
   output logic [PW-1:0] ap_q,
   output logic          done,
   output logic          cvt_half
);
   localparam logic [PW-1:0] FULL = PW'(NBITS);
   localparam logic [PW-1:0] TOP  = PW'(NBITS - 1);

   sar_state_t    st;
   logic [PW-1:0] ap_eff;
   logic [PW-1:0] lo_idx;
   logic          finish;

   assign ap_eff   = (prec == '0 || prec > FULL) ? FULL : prec;
   assign lo_idx   = FULL - ap_q;
   assign last_bit = (bit_idx == lo_idx);
   assign finish   = (st == ST_AVG) && last_bit;

   assign cmpt_stb = (st == ST_CMPT);
   assign pch_stb  = (st == ST_PCH);
   assign avg_stb  = (st == ST_AVG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bit_idx  <= '0;
         ap_q     <= FULL;
         done     <= 1'b0;
         cvt_half <= 1'b0;
      end else begin
         done <= finish;
         if (finish) cvt_half <= ~cvt_half;
         unique case (st)
            ST_IDLE: if (start) begin
               st   <= ST_CMPT;
               ap_q <= ap_eff;
            end
            ST_CMPT: begin
               st      <= ST_PCH;
               bit_idx <= TOP;
            end
            ST_PCH: st <= ST_AVG;
            ST_AVG: begin
               if (last_bit) st <= ST_IDLE;
               else begin
                  st      <= ST_PCH;
                  bit_idx <= bit_idx - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2
   pch_then_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pch_stb |=> avg_stb);
   // R2
   cmpt_then_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmpt_stb |=> (pch_stb && bit_idx == TOP));
   // R8
   avg_next_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_stb && !last_bit) |=> pch_stb);
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   done_after_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(avg_stb));
   // R7
   half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cvt_half != $past(cvt_half)));
   // R3
   prec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmpt_stb |-> (ap_q >= PW'(1) && ap_q <= FULL));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int unsigned NBITS = 5,
   parameter int unsigned PW    = $clog2(NBITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             upd,
   input  logic             last_bit,
   input  logic [PW-1:0]    bit_idx,
   input  logic             cmp_hi,
   output logic [NBITS-1:0] trial,
   output logic [NBITS-1:0] code
);
   localparam logic [NBITS-1:0] ONE = NBITS'(1);
   localparam logic [NBITS-1:0] MID = ONE << (NBITS - 1);

   logic [NBITS-1:0] cur_bit;
   logic [NBITS-1:0] nxt;

   assign cur_bit = ONE << bit_idx;

   always_comb begin
      nxt = trial;
      if (!cmp_hi)   nxt = nxt & ~cur_bit;
      if (!last_bit) nxt = nxt | (cur_bit >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trial <= '0;
         code  <= '0;
      end else begin
         if (ld)       trial <= MID;
         else if (upd) trial <= nxt;
         if (upd && last_bit) code <= nxt;
      end
   end

   // R5
   mid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (trial == MID));
   // R5
   keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && cmp_hi) |=> ((trial & $past(cur_bit)) != '0));
   // R5
   drop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !cmp_hi) |=> ((trial & $past(cur_bit)) == '0));
   // R6
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd && last_bit) |=> $stable(code));
endmodule

// File: rtl/sar_therm_enc.sv
module sar_therm_enc #(
   parameter int unsigned NBITS  = 5,
   parameter int unsigned NLINES = (1 << NBITS) - 1
) (
   input  logic              en,
   input  logic [NBITS-1:0]  value,
   output logic [NLINES-1:0] lines
);
   generate
      for (genvar j = 0; j < NLINES; j++) begin : g_line
         localparam logic [NBITS:0] IDX = (NBITS + 1)'(j);
         assign lines[j] = en && (IDX < {1'b0, value});
      end
   endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
   parameter int unsigned NBITS  = 5,
   parameter int unsigned NLINES = (1 << NBITS) - 1,
   parameter int unsigned PW     = $clog2(NBITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PW-1:0]     prec,
   input  logic              cmp_hi,
   output logic [NLINES-1:0] line_en,
   output logic              cmpt_stb,
   output logic              pch_stb,
   output logic              avg_stb,
   output logic              cvt_half,
   output logic [NBITS-1:0]  code,
   output logic              done
);
   generate
      if (NBITS < 1 || NBITS > 10) begin : g_bad_bits
         $error("sar_seq: NBITS must lie in 1..10");
      end
      if (NLINES != (1 << NBITS) - 1) begin : g_bad_lines
         $error("sar_seq: NLINES must equal 2**NBITS - 1");
      end
      if (PW < $clog2(NBITS + 1)) begin : g_bad_pw
         $error("sar_seq: PW too narrow for NBITS");
      end
   endgenerate

   logic [PW-1:0]    bit_idx;
   logic [PW-1:0]    ap_q;
   logic             last_bit;
   logic [NBITS-1:0] trial;

   sar_phase_ctrl #(.NBITS(NBITS), .PW(PW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .prec     (prec),
      .cmpt_stb (cmpt_stb),
      .pch_stb  (pch_stb),
      .avg_stb  (avg_stb),
      .bit_idx  (bit_idx),
      .last_bit (last_bit),
      .ap_q     (ap_q),
      .done     (done),
      .cvt_half (cvt_half)
   );

   sar_trial_reg #(.NBITS(NBITS), .PW(PW)) u_trial (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (cmpt_stb),
      .upd      (avg_stb),
      .last_bit (last_bit),
      .bit_idx  (bit_idx),
      .cmp_hi   (cmp_hi),
      .trial    (trial),
      .code     (code)
   );

   sar_therm_enc #(.NBITS(NBITS), .NLINES(NLINES)) u_therm (
      .en    (pch_stb),
      .value (trial),
      .lines (line_en)
   );

   logic [NBITS-1:0] low_mask;
   assign low_mask = NBITS'((1 << (NBITS - int'(ap_q))) - 1);

   // R4
   line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pch_stb |-> ($countones(line_en) == int'(trial)));
   // R4
   line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pch_stb |-> (line_en == '0));
   // R6
   low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((code & low_mask) == '0));
   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmpt_stb, pch_stb, avg_stb}));
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
   localparam int NB = 5;
   localparam int NL = 31;
   localparam int PWT = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [PWT-1:0] prec;
   logic          cmp_hi;
   logic [NL-1:0] line_en;
   logic          cmpt_stb, pch_stb, avg_stb, cvt_half, done;
   logic [NB-1:0] code;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   bit half_exp = 0;

   always #10 clk = ~clk;

   sar_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .prec(prec), .cmp_hi(cmp_hi),
      .line_en(line_en), .cmpt_stb(cmpt_stb), .pch_stb(pch_stb),
      .avg_stb(avg_stb), .cvt_half(cvt_half), .code(code), .done(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic convert(input int v, input int p, input bit poke);
      int ap = (p == 0 || p > NB) ? NB : p;
      int lo = NB - ap;
      int tm = 1 << (NB - 1);
      int b = NB - 1;
      int exp_code = v & ~((1 << lo) - 1);
      bit fin = 0;
      logic [31:0] therm;
      @(negedge clk);
      start = 1'b1;
      prec = PWT'(p);
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= 40 && !fin; k++) begin
         if (poke) start = (k == 2 || k == 3);
         if (k == 1) begin
            // R2 compute cycle first
            chk({cmpt_stb, pch_stb, avg_stb} == 3'b100, "R2 cmpt", {cmpt_stb, pch_stb, avg_stb}, 4);
         end else if (k <= 1 + 2 * ap) begin
            if (k % 2 == 0) begin
               // R2 precharge, R4 thermometer, R5 trial sequence
               chk({cmpt_stb, pch_stb, avg_stb} == 3'b010, "R2 pch", {cmpt_stb, pch_stb, avg_stb}, 2);
               therm = (32'd1 << tm) - 32'd1;
               chk(line_en == therm[NL-1:0], "R4/R5 lines", line_en, therm[NL-1:0]);
            end else begin
               chk({cmpt_stb, pch_stb, avg_stb} == 3'b001, "R2 avg", {cmpt_stb, pch_stb, avg_stb}, 1);
               // R4 no enables outside precharge
               chk(line_en == '0, "R4 idle lines", line_en, 0);
               cmp_hi = (v >= tm);
               if (!(v >= tm)) tm = tm & ~(1 << b);
               if (b > lo) tm = tm | (1 << (b - 1));
               b--;
            end
            chk(done == 1'b0, "R9 early done", done, 0);
         end else begin
            // R3 length from precision, R6 code, R7 half swap, R9 done
            chk(k == 2 + 2 * ap, "R3 length", k, 2 + 2 * ap);
            chk(done == 1'b1, "R9 done", done, 1);
            chk({cmpt_stb, pch_stb, avg_stb} == 3'b000, "R2 end idle", {cmpt_stb, pch_stb, avg_stb}, 0);
            chk(int'(code) == exp_code, "R6 code", code, exp_code);
            half_exp = ~half_exp;
            chk(cvt_half == half_exp, "R7 half", cvt_half, half_exp);
            fin = 1;
         end
         if (!fin) @(negedge clk);
      end
      if (!fin) chk(1'b0, "R2 no done", 0, 1);
      start = 1'b0;
      @(negedge clk);
      // R9 single pulse; R6 code held; R8 no restart after a busy poke
      chk(done == 1'b0, "R9 pulse width", done, 0);
      chk(int'(code) == exp_code, "R6 hold", code, exp_code);
      chk(cmpt_stb == 1'b0, "R8 no restart", cmpt_stb, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      prec = '0;
      cmp_hi = 1'b0;
      repeat (3) @(negedge clk);
      // R1 state held in reset
      chk({cmpt_stb, pch_stb, avg_stb, done, cvt_half} == 5'b0, "R1 in reset",
          {cmpt_stb, pch_stb, avg_stb, done, cvt_half}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(line_en == '0 && code == '0, "R1 after reset", code, 0);
      chk({cmpt_stb, pch_stb, avg_stb, done, cvt_half} == 5'b0, "R1 strobes",
          {cmpt_stb, pch_stb, avg_stb, done, cvt_half}, 0);
      for (int p = 0; p <= 7; p++) begin
         if (p == 6) continue;
         for (int v = 0; v < 32; v++) convert(v, p, 1'b0);
      end
      // R8 start pulses inside a conversion
      for (int v = 0; v < 32; v += 5) begin
         convert(v, 3, 1'b1);
         convert(v, 5, 1'b1);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule